// File: doc/BRIEF.md
# Abort Timestamp and Cause Status Latch

This block records when a beam abort happened and why. A free-running counter advances once per microsecond tick. It returns to zero whenever the incoming event stream delivers the code held in a programmable reset-code input, so the count always measures microseconds since the last reset event. When an abort pulse arrives, the current count is copied into a timestamp register. At the same moment a real-time-abort flag is set, and that flag freezes the three cause flags: dump request, permit failure and missed fiducial.

The timestamp and the frozen flags stay in place as one coherent record until software reads the timestamp. The read strobe releases the record. While the record is released, the dump flag follows dump-code events, the permit-failure flag follows carrier loss and requalification, and the fiducial-failure flag is refreshed once per revolution. A level-sensitive interrupt request combines the flags with two enable bits, one for each status group.

Top module: `abort_stamp_status`

## Requirements
- R1: The counter increases by one on each cycle in which `us_tick_i` is high, and wraps modulo 2^TS_W.
- R2: An event whose code equals `reset_code_i` sets the counter to zero. It overrides a tick in the same cycle.
- R3: An abort with no unread record sets `timestamp_o` to the count present in that cycle. A later abort before the next read leaves `timestamp_o` unchanged.
- R4: An event whose code equals `dump_code_i` sets `dump_flag_o` unless the record is frozen. A timestamp read without a concurrent abort clears it.
- R5: `rt_abort_o` sets on a capturing abort and clears on a read without a concurrent abort. While it is set and no read occurs, `dump_flag_o`, `permit_fail_o` and `fid_fail_o` do not change.
- R6: When an abort and a read fall in the same cycle, the abort wins: a fresh count is captured and `rt_abort_o` stays set.
- R7: `permit_fail_o` sets one cycle after `carrier_ok_i` is low while the record is not frozen. It clears only after QUAL_TICKS consecutive ticks with the carrier present.
- R8: On a cycle in which `rev_tick_i` is high and the record is not frozen, `fid_fail_o` becomes 1 if no `fid_seen_i` pulse occurred since the previous revolution strike, including the current cycle. Otherwise it becomes 0.
- R9: `irq_o` equals (`irq_en_stat1_i` AND (`rt_abort_o` OR `dump_flag_o`)) OR (`irq_en_stat2_i` AND (`permit_fail_o` OR `fid_fail_o`)). It stays high as long as that condition holds.
- R10: After reset, the timestamp, the counter and all four flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle microsecond tick |
| evt_valid_i | input | 1 | Event code strobe |
| evt_code_i | input | CODE_W | Received event code |
| reset_code_i | input | CODE_W | Code that zeroes the counter |
| dump_code_i | input | CODE_W | Code that requests a dump |
| abort_i | input | 1 | Abort pulse |
| carrier_ok_i | input | 1 | Permit carrier present |
| fid_seen_i | input | 1 | Revolution fiducial detected |
| rev_tick_i | input | 1 | End of a revolution window |
| ts_read_i | input | 1 | Timestamp read strobe |
| irq_en_stat1_i | input | 1 | Interrupt enable, abort/dump group |
| irq_en_stat2_i | input | 1 | Interrupt enable, permit/fiducial group |
| timestamp_o | output | TS_W | Captured abort time |
| rt_abort_o | output | 1 | Unread abort record present |
| dump_flag_o | output | 1 | Dump code seen |
| permit_fail_o | output | 1 | Permit carrier failure |
| fid_fail_o | output | 1 | Fiducial missed in last revolution |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with TS_W=8 and QUAL_TICKS=20. An 8-bit counter makes the wrap reachable: a capture after 256 or 300 ticks lands on 0 or 44. A 20-tick qualification window lets the bench watch the permit-failure flag hold through 19 carrier ticks and release after the 20th. The table covers counts from zero through the wrap, and directed cases cover the reset-code/tick overlap, a second abort before a read, and an abort coinciding with a read.

// File: rtl/abort_status_pkg.sv
package abort_status_pkg;
  typedef struct packed {
    logic rt_abort;
    logic dump;
    logic permit_fail;
    logic fid_fail;
  } status_t;
endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            tick_i,
  output logic [TS_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (clear_i) count_o <= '0;
    else if (tick_i)  count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/permit_qualifier.sv
module permit_qualifier #(
  parameter int QUAL_TICKS = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carrier_ok_i,
  input  logic tick_i,
  output logic qualified_o
);
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_TICKS);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!carrier_ok_i)            cnt_q <= '0;
    else if (tick_i && cnt_q != QMAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign qualified_o = (cnt_q == QMAX);
endmodule

// File: rtl/fiducial_monitor.sv
module fiducial_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fid_i,
  input  logic rev_tick_i,
  output logic missed_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seen_q <= 1'b0;
    else if (rev_tick_i) seen_q <= 1'b0;
    else if (fid_i)      seen_q <= 1'b1;
  end

  // a fiducial coincident with the window end still counts
  assign missed_o = !(seen_q || fid_i);
endmodule

// File: rtl/abort_stamp_status.sv
module abort_stamp_status
  import abort_status_pkg::*;
#(
  parameter int TS_W       = 32,
  parameter int CODE_W     = 8,
  parameter int QUAL_TICKS = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              us_tick_i,
  input  logic              evt_valid_i,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic [CODE_W-1:0] reset_code_i,
  input  logic [CODE_W-1:0] dump_code_i,
  input  logic              abort_i,
  input  logic              carrier_ok_i,
  input  logic              fid_seen_i,
  input  logic              rev_tick_i,
  input  logic              ts_read_i,
  input  logic              irq_en_stat1_i,
  input  logic              irq_en_stat2_i,
  output logic [TS_W-1:0]   timestamp_o,
  output logic              rt_abort_o,
  output logic              dump_flag_o,
  output logic              permit_fail_o,
  output logic              fid_fail_o,
  output logic              irq_o
);
  logic [TS_W-1:0] cnt_q;
  logic [TS_W-1:0] ts_q;
  status_t         stat_q;
  logic            evt_reset, evt_dump;
  logic            qualified, fid_missed;
  logic            frozen, capture;

  assign evt_reset = evt_valid_i && (evt_code_i == reset_code_i);
  assign evt_dump  = evt_valid_i && (evt_code_i == dump_code_i);

  stamp_counter #(.TS_W(TS_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (evt_reset),
    .tick_i  (us_tick_i),
    .count_o (cnt_q)
  );

  permit_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .carrier_ok_i (carrier_ok_i),
    .tick_i       (us_tick_i),
    .qualified_o  (qualified)
  );

  fiducial_monitor u_fid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fid_i      (fid_seen_i),
    .rev_tick_i (rev_tick_i),
    .missed_o   (fid_missed)
  );

  assign frozen  = stat_q.rt_abort && !ts_read_i;
  assign capture = abort_i && (!stat_q.rt_abort || ts_read_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q   <= '0;
      stat_q <= '0;
    end else begin
      if (capture) begin
        ts_q            <= cnt_q;
        stat_q.rt_abort <= 1'b1;
      end else if (ts_read_i) begin
        stat_q.rt_abort <= 1'b0;
      end

      if (!frozen) begin
        if (evt_dump)                    stat_q.dump <= 1'b1;
        else if (ts_read_i && !capture)  stat_q.dump <= 1'b0;

        if (!carrier_ok_i)   stat_q.permit_fail <= 1'b1;
        else if (qualified)  stat_q.permit_fail <= 1'b0;

        if (rev_tick_i)      stat_q.fid_fail <= fid_missed;
      end
    end
  end

  assign timestamp_o   = ts_q;
  assign rt_abort_o    = stat_q.rt_abort;
  assign dump_flag_o   = stat_q.dump;
  assign permit_fail_o = stat_q.permit_fail;
  assign fid_fail_o    = stat_q.fid_fail;
  assign irq_o = (irq_en_stat1_i && (stat_q.rt_abort || stat_q.dump)) ||
                 (irq_en_stat2_i && (stat_q.permit_fail || stat_q.fid_fail));
endmodule

// File: rtl/abort_stamp_status_chk.sv
module abort_stamp_status_chk #(
  parameter int TS_W   = 32,
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_valid_i,
  input logic [CODE_W-1:0] evt_code_i,
  input logic [CODE_W-1:0] reset_code_i,
  input logic [CODE_W-1:0] dump_code_i,
  input logic              abort_i,
  input logic              carrier_ok_i,
  input logic              fid_seen_i,
  input logic              rev_tick_i,
  input logic              ts_read_i,
  input logic              irq_en_stat1_i,
  input logic              irq_en_stat2_i,
  input logic [TS_W-1:0]   cnt_i,
  input logic [TS_W-1:0]   timestamp_o,
  input logic              rt_abort_o,
  input logic              dump_flag_o,
  input logic              permit_fail_o,
  input logic              fid_fail_o,
  input logic              irq_o
);
  p_count_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && evt_code_i == reset_code_i |=> cnt_i == '0);

  p_hold_stamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_abort_o && !ts_read_i |=> $stable(timestamp_o) && rt_abort_o);

  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_read_i && !abort_i |=> !rt_abort_o);

  p_read_clears_dump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_read_i && !abort_i && !(evt_valid_i && evt_code_i == dump_code_i) |=> !dump_flag_o);

  p_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_abort_o && !ts_read_i |=> $stable(dump_flag_o) && $stable(permit_fail_o) && $stable(fid_fail_o));

  p_abort_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && ts_read_i |=> rt_abort_o && timestamp_o == $past(cnt_i));

  p_loss_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carrier_ok_i && !rt_abort_o |=> permit_fail_o);

  p_fid_ok_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_tick_i && fid_seen_i && !rt_abort_o |=> !fid_fail_o);

  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_stat1_i && !irq_en_stat2_i |-> !irq_o);
endmodule

bind abort_stamp_status abort_stamp_status_chk #(.TS_W(TS_W), .CODE_W(CODE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .evt_valid_i    (evt_valid_i),
  .evt_code_i     (evt_code_i),
  .reset_code_i   (reset_code_i),
  .dump_code_i    (dump_code_i),
  .abort_i        (abort_i),
  .carrier_ok_i   (carrier_ok_i),
  .fid_seen_i     (fid_seen_i),
  .rev_tick_i     (rev_tick_i),
  .ts_read_i      (ts_read_i),
  .irq_en_stat1_i (irq_en_stat1_i),
  .irq_en_stat2_i (irq_en_stat2_i),
  .cnt_i          (cnt_q),
  .timestamp_o    (timestamp_o),
  .rt_abort_o     (rt_abort_o),
  .dump_flag_o    (dump_flag_o),
  .permit_fail_o  (permit_fail_o),
  .fid_fail_o     (fid_fail_o),
  .irq_o          (irq_o)
);

// File: tb/abort_stamp_status_tb_top.sv
module abort_stamp_status_tb_top;
  localparam int TS_W = 8;
  localparam int CODE_W = 8;
  localparam int QUAL_TICKS = 20;
  localparam int N_VEC = 7;
  localparam int unsigned TICKS[N_VEC] = '{0, 1, 5, 100, 255, 256, 300};
  localparam int unsigned EXP_TS[N_VEC] = '{0, 1, 5, 100, 255, 0, 44};
  localparam logic [7:0] RST_CODE = 8'h3C;
  localparam logic [7:0] DMP_CODE = 8'hA5;

  logic clk = 0, rst_n = 0;
  logic us_tick = 0, evt_valid = 0, abort = 0, carrier_ok = 1;
  logic fid_seen = 0, rev_tick = 0, ts_read = 0, en1 = 0, en2 = 0;
  logic [CODE_W-1:0] evt_code = '0;
  logic [TS_W-1:0] timestamp;
  logic rt_abort, dump_flag, permit_fail, fid_fail, irq;
  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  abort_stamp_status #(.TS_W(TS_W), .CODE_W(CODE_W), .QUAL_TICKS(QUAL_TICKS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(us_tick), .evt_valid_i(evt_valid),
    .evt_code_i(evt_code), .reset_code_i(RST_CODE), .dump_code_i(DMP_CODE),
    .abort_i(abort), .carrier_ok_i(carrier_ok), .fid_seen_i(fid_seen),
    .rev_tick_i(rev_tick), .ts_read_i(ts_read), .irq_en_stat1_i(en1),
    .irq_en_stat2_i(en2), .timestamp_o(timestamp), .rt_abort_o(rt_abort),
    .dump_flag_o(dump_flag), .permit_fail_o(permit_fail), .fid_fail_o(fid_fail),
    .irq_o(irq)
  );

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    us_tick = 0; evt_valid = 0; abort = 0; fid_seen = 0; rev_tick = 0; ts_read = 0;
  endtask

  task automatic send_evt(input logic [7:0] c);
    evt_valid = 1; evt_code = c; step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin us_tick = 1; step(); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R10 ts", timestamp, 0);
    check("R10 flags", {rt_abort, dump_flag, permit_fail, fid_fail}, 0);
    check("R9 irq idle", irq, 0);

    // R1 R2 R3: capture table
    for (int v = 0; v < N_VEC; v++) begin
      send_evt(RST_CODE);
      ticks(TICKS[v]);
      abort = 1; step();
      check("R1/R3 captured ts", timestamp, EXP_TS[v]);
      check("R5 rt set", rt_abort, 1);
      ts_read = 1; step();
      check("R5 rt cleared", rt_abort, 0);
    end

    // R2: reset code beats a same-cycle tick
    ticks(7);
    evt_valid = 1; evt_code = RST_CODE; us_tick = 1; step();
    abort = 1; step();
    check("R2 clear over tick", timestamp, 0);
    ts_read = 1; step();

    // R3: second abort before read ignored; R6: abort with read wins
    send_evt(RST_CODE);
    ticks(3); abort = 1; step();
    ticks(4); abort = 1; step();
    check("R3 second abort ignored", timestamp, 3);
    ticks(2); abort = 1; ts_read = 1; step();
    check("R6 abort+read ts", timestamp, 9);
    check("R6 rt stays", rt_abort, 1);
    ts_read = 1; step();

    // R4 and R9 on status group 1
    send_evt(DMP_CODE);
    check("R4 dump set", dump_flag, 1);
    check("R9 masked", irq, 0);
    en1 = 1; #1;
    check("R9 enabled", irq, 1);
    en1 = 0;
    ts_read = 1; step();
    check("R4 dump cleared", dump_flag, 0);

    // R5 freeze
    abort = 1; step();
    carrier_ok = 0; step();
    send_evt(DMP_CODE);
    check("R5 pf frozen", permit_fail, 0);
    check("R5 dump frozen", dump_flag, 0);
    ts_read = 1; step();
    check("R5 released rt", rt_abort, 0);
    check("R7 pf set", permit_fail, 1);

    // R7 requalification
    carrier_ok = 1;
    ticks(QUAL_TICKS - 1);
    check("R7 pf held", permit_fail, 1);
    ticks(1); step();
    check("R7 pf cleared", permit_fail, 0);

    // R8 fiducial window
    fid_seen = 1; step();
    rev_tick = 1; step();
    check("R8 seen", fid_fail, 0);
    rev_tick = 1; step();
    check("R8 missed", fid_fail, 1);
    check("R9 grp2 masked", irq, 0);
    en2 = 1; #1;
    check("R9 grp2 enabled", irq, 1);
    en2 = 0;
    abort = 1; step();
    fid_seen = 1; rev_tick = 1; step();
    check("R5 fid frozen", fid_fail, 1);
    ts_read = 1; step();
    fid_seen = 1; rev_tick = 1; step();
    check("R8 same-cycle seen", fid_fail, 0);

    finish_run();
  end
endmodule